// File: doc/BRIEF.md
# Windowed Watchdog with Keyed Refresh and Unlock

This block is a watchdog timer attached to a small 16-bit register bus. A 32-bit down-counter is loaded from a programmable time-out value. Software keeps the system alive by writing a two-word refresh key to the refresh register. When windowing is on, the refresh is accepted only after a minimum number of cycles has passed since the last reload. Every configuration register is write-protected. It opens for a limited number of cycles after a separate two-word unlock key is written.

Several events count as faults: the counter reaching zero, a wrong second key word, a second key word that is too late, and a refresh that comes too early. With the interrupt option enabled, a fault sets a sticky flag that drives the interrupt output. A reset pulse still follows a fixed grace period later. A time-out during that grace period cuts it short and issues the reset at once. With the interrupt option off, a fault issues the reset at once.

Top module: `wdt_seq_guard`

## Requirements
- R1: After reset the registers read as follows: address 0 (control high) 0x01D3, address 1 (control low) 0x0001, address 2 (time-out high) 0x004C, address 3 (time-out low) 0x4B4C, address 4 (window high) 0x0000, address 5 (window low) 0x0010. Both irq and wdt_rst are low. In control high, bit 0 enables counting, bit 2 enables the interrupt and bit 3 enables windowing. Bit 15 of control low is the interrupt flag.
- R2: Writes to addresses 0 and 2..5 take effect only when an unlock has completed within the previous UNLOCK_WIN (256) cycles. An unlock is 0xC520 then 0xD928 written to address 7. A write 256 cycles after the completing word is accepted, and one 257 cycles after it is ignored.
- R3: A refresh is 0xA602 then 0xB480 written to address 6, with the second word at most 20 cycles after the first. It reloads the counter from the time-out value and causes no fault.
- R4: If the word written to address 6 or address 7 after its first key word is anything other than the matching second key word, a fault occurs.
- R5: If no write reaches the armed address within 20 cycles of the first key word, a fault occurs. For either sequence, the flag rises 21 cycles after the first word.
- R6: When enabled, the counter holds the time-out value T in the cycle after a reload and counts down by one each cycle. It reaches zero T cycles later, and that cycle is a time-out fault that also reloads the counter.
- R7: With the interrupt enabled, a fault sets the flag and raises irq in the next cycle. wdt_rst then rises exactly WCT cycles after irq rises.
- R8: Writing 1 to bit 15 of address 1 clears the flag. This needs no unlock. Writing 0 to bit 15 leaves the flag set.
- R9: With the interrupt disabled, a fault raises wdt_rst in the next cycle and irq stays low.
- R10: A time-out during the grace period raises wdt_rst in the next cycle, without waiting for the grace period to end.
- R11: With windowing enabled, a refresh whose second word arrives when the elapsed count is below the window value is a fault. The elapsed count is the time-out value minus the counter. A refresh with an elapsed count equal to the window value is accepted.
- R12: Each wdt_rst pulse lasts exactly RST_LEN cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt, follows the sticky flag |
| wdt_rst | output | 1 | Watchdog reset pulse |

## Verification
The key sequences are driven with the second word back to back, at exactly 20 cycles, and never sent. A wrong second word is also sent. Together these separate a bounded gap check from an off-by-one one, and a value check from a gap check, for both the refresh and the unlock register. The fault path is tried four ways: with the interrupt off, with the interrupt on and a grace period left to expire, with a time-out landing inside the grace period, and with an early refresh under windowing. Each case has its own predicted cycle for the irq and reset edges, so a wrong delay or a missed backup shows up as a timing mismatch. The unlock window is probed at 256 and 257 cycles to pin down its exact length.

// File: rtl/wdt_pkg.sv
// Shared constants and types for the keyed windowed watchdog.
// Assumes a 16-bit bus with word addresses; the register layout is fixed here.
package wdt_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] A_CTRL_HI = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL_LO = 3'd1;
    localparam logic [ADDR_W-1:0] A_TOV_HI  = 3'd2;
    localparam logic [ADDR_W-1:0] A_TOV_LO  = 3'd3;
    localparam logic [ADDR_W-1:0] A_WIN_HI  = 3'd4;
    localparam logic [ADDR_W-1:0] A_WIN_LO  = 3'd5;
    localparam logic [ADDR_W-1:0] A_KICK    = 3'd6;
    localparam logic [ADDR_W-1:0] A_KEY     = 3'd7;

    localparam logic [DATA_W-1:0] KICK_ARM  = 16'hA602;
    localparam logic [DATA_W-1:0] KICK_FIRE = 16'hB480;
    localparam logic [DATA_W-1:0] KEY_ARM   = 16'hC520;
    localparam logic [DATA_W-1:0] KEY_FIRE  = 16'hD928;

    localparam logic [DATA_W-1:0]   RV_CTRL_HI = 16'h01D3;
    localparam logic [DATA_W-1:0]   RV_CTRL_LO = 16'h0001;
    localparam logic [2*DATA_W-1:0] RV_TOV     = 32'h004C_4B4C;
    localparam logic [2*DATA_W-1:0] RV_WIN     = 32'h0000_0010;

    localparam int B_EN     = 0;
    localparam int B_IRQ_EN = 2;
    localparam int B_WIN_EN = 3;
    localparam int B_FLAG   = 15;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRACE = 2'd1,
        ST_RESET = 2'd2
    } wd_state_e;
endpackage

// File: rtl/wdt_seq_chk.sv
// Two-word key sequence checker.
// Arms on ARM written to its address, then expects FIRE as the next write to
// that address within GAP_MAX cycles. Reports done on a correct second word,
// fault on a wrong one or on silence past the gap. Assumes wr_hit is
// already qualified by the address.
module wdt_seq_chk #(
    parameter logic [15:0] ARM     = 16'hA602,
    parameter logic [15:0] FIRE    = 16'hB480,
    parameter int          GAP_MAX = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_hit,
    input  logic [15:0] wdata,
    output logic        done,
    output logic        fault
);
    localparam int GW = $clog2(GAP_MAX + 1);

    logic          armed;
    logic [GW-1:0] gap;
    logic          late;
    logic          bad_val;

    // Decode the outcome of the current cycle for an armed sequence.
    always_comb begin
        done    = armed && wr_hit && (wdata == FIRE);
        bad_val = armed && wr_hit && (wdata != FIRE);
        late    = armed && !wr_hit && (gap == GW'(GAP_MAX));
        fault   = bad_val || late;
    end

    // Arm on the first word and count cycles until the second word or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            gap   <= '0;
        end else if (armed) begin
            if (wr_hit || late) armed <= 1'b0;
            else                gap   <= gap + GW'(1);
        end else if (wr_hit && (wdata == ARM)) begin
            armed <= 1'b1;
            gap   <= GW'(1);
        end
    end

    // R5
    gap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(armed)) |-> (gap == $past(gap) + GW'(1)));

    // R3
    done_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !armed);
endmodule

// File: rtl/wdt_regs.sv
// Register file with the timed write lock and the sticky interrupt flag.
// Configuration writes pass only while the unlock window counter is nonzero;
// the flag clear (write one) is always allowed. Reads are combinational.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int UNLOCK_WIN = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              unlock_done,
    input  logic              flag_set,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              en,
    output logic              irq_en,
    output logic              win_en,
    output logic [31:0]       tov,
    output logic [31:0]       win,
    output logic              flag
);
    localparam int UW = $clog2(UNLOCK_WIN + 1);

    logic [UW-1:0]     ulk_cnt;
    logic              cfg_we;
    logic [DATA_W-1:0] ctrl_hi_q, tov_hi_q, tov_lo_q, win_hi_q, win_lo_q;

    assign cfg_we = bus_wr && (ulk_cnt != '0);
    assign en     = ctrl_hi_q[B_EN];
    assign irq_en = ctrl_hi_q[B_IRQ_EN];
    assign win_en = ctrl_hi_q[B_WIN_EN];
    assign tov    = {tov_hi_q, tov_lo_q};
    assign win    = {win_hi_q, win_lo_q};

    // Open the write window on an unlock and let it run down.
    always_ff @(posedge clk) begin
        if (!rst_n)                ulk_cnt <= '0;
        else if (unlock_done)      ulk_cnt <= UW'(UNLOCK_WIN);
        else if (ulk_cnt != '0)    ulk_cnt <= ulk_cnt - UW'(1);
    end

    // Hold the protected configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_hi_q <= RV_CTRL_HI;
            tov_hi_q  <= RV_TOV[31:16];
            tov_lo_q  <= RV_TOV[15:0];
            win_hi_q  <= RV_WIN[31:16];
            win_lo_q  <= RV_WIN[15:0];
        end else if (cfg_we) begin
            case (bus_addr)
                A_CTRL_HI: ctrl_hi_q <= bus_wdata;
                A_TOV_HI:  tov_hi_q  <= bus_wdata;
                A_TOV_LO:  tov_lo_q  <= bus_wdata;
                A_WIN_HI:  win_hi_q  <= bus_wdata;
                A_WIN_LO:  win_lo_q  <= bus_wdata;
                default:   ;
            endcase
        end
    end

    // Sticky flag: set by a fault, cleared by writing one; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (flag_set) flag <= 1'b1;
        else if (bus_wr && (bus_addr == A_CTRL_LO) && bus_wdata[B_FLAG])
            flag <= 1'b0;
    end

    // Return the addressed register.
    always_comb begin
        case (bus_addr)
            A_CTRL_HI: bus_rdata = ctrl_hi_q;
            A_CTRL_LO: bus_rdata = RV_CTRL_LO | {flag, 15'd0};
            A_TOV_HI:  bus_rdata = tov_hi_q;
            A_TOV_LO:  bus_rdata = tov_lo_q;
            A_WIN_HI:  bus_rdata = win_hi_q;
            A_WIN_LO:  bus_rdata = win_lo_q;
            default:   bus_rdata = '0;
        endcase
    end

    // R2
    locked_tov_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == A_TOV_LO) && (ulk_cnt == '0)) |=> $stable(tov_lo_q));

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set |=> flag);

    // R8
    w0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && bus_wr && (bus_addr == A_CTRL_LO) && !bus_wdata[B_FLAG]) |=> flag);
endmodule

// File: rtl/wdt_core.sv
// Down-counter, window test and fault sequencer.
// A fault either opens a WCT-cycle grace period (interrupt enabled) or goes
// straight to a RST_LEN-cycle reset pulse. A time-out during the grace period
// forces the pulse at once. Faults seen during the pulse are dropped.
module wdt_core
    import wdt_pkg::*;
#(
    parameter int WCT     = 256,
    parameter int RST_LEN = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        irq_en,
    input  logic        win_en,
    input  logic [31:0] tov,
    input  logic [31:0] win,
    input  logic        kick_done,
    input  logic        seq_fault,
    output logic        flag_set,
    output logic        wdt_rst
);
    localparam int WW = $clog2(WCT + 1);
    localparam int RW = $clog2(RST_LEN + 1);

    wd_state_e     state;
    logic [31:0]   cnt;
    logic [31:0]   elapsed;
    logic [WW-1:0] wct_cnt;
    logic [RW-1:0] rst_cnt;
    logic          win_bad, kick_ok, tmo, fault;

    // Classify this cycle's refresh and time-out.
    always_comb begin
        elapsed  = tov - cnt;
        win_bad  = win_en && kick_done && (elapsed < win);
        kick_ok  = kick_done && !win_bad;
        tmo      = en && (cnt == '0) && !kick_ok;
        fault    = tmo || seq_fault || win_bad;
        flag_set = (state == ST_IDLE) && fault && irq_en;
        wdt_rst  = (state == ST_RESET);
    end

    // Count down, reloading on a good refresh, on expiry or while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt <= RV_TOV;
        else if (!en || kick_ok || cnt == '0) cnt <= tov;
        else                                  cnt <= cnt - 32'd1;
    end

    // Step through idle, grace period and reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            wct_cnt <= '0;
            rst_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (fault && irq_en) begin
                        state   <= ST_GRACE;
                        wct_cnt <= WW'(WCT - 1);
                    end else if (fault) begin
                        state   <= ST_RESET;
                        rst_cnt <= RW'(RST_LEN - 1);
                    end
                end
                ST_GRACE: begin
                    if (tmo || wct_cnt == '0) begin
                        state   <= ST_RESET;
                        rst_cnt <= RW'(RST_LEN - 1);
                    end else begin
                        wct_cnt <= wct_cnt - WW'(1);
                    end
                end
                ST_RESET: begin
                    if (rst_cnt == '0) state   <= ST_IDLE;
                    else               rst_cnt <= rst_cnt - RW'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10
    backup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GRACE && tmo) |=> wdt_rst);

    // R7
    grace_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GRACE && !tmo && wct_cnt != '0) |=> !wdt_rst);

    // R9
    direct_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && fault && !irq_en) |=> (wdt_rst && !flag_set));

    // R6
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> (cnt == $past(tov)));

    // R12
    pulse_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (RST_LEN > 1 && $rose(wdt_rst)) |=> wdt_rst);
endmodule

// File: rtl/wdt_seq_guard.sv
// Top of the keyed windowed watchdog. It wires two sequence checkers
// (refresh and unlock), the register file and the counter core. irq follows
// the sticky flag. Assumes at most one bus write per cycle.
module wdt_seq_guard
    import wdt_pkg::*;
#(
    parameter int WCT        = 256,
    parameter int RST_LEN    = 16,
    parameter int GAP_MAX    = 20,
    parameter int UNLOCK_WIN = 256
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic [wdt_pkg::ADDR_W-1:0] bus_addr,
    input  logic [15:0]               bus_wdata,
    output logic [15:0]               bus_rdata,
    output logic                      irq,
    output logic                      wdt_rst
);
    localparam int NSEQ = 2;

    logic [NSEQ-1:0] seq_done;
    logic [NSEQ-1:0] seq_fault;
    logic            en, irq_en, win_en, flag, flag_set;
    logic [31:0]     tov, win;

    // Checker 0 guards the refresh register, checker 1 the unlock register.
    for (genvar i = 0; i < NSEQ; i++) begin : g_seq
        localparam logic [15:0]       ARM_V  = (i == 0) ? KICK_ARM  : KEY_ARM;
        localparam logic [15:0]       FIRE_V = (i == 0) ? KICK_FIRE : KEY_FIRE;
        localparam logic [ADDR_W-1:0] HIT_A  = (i == 0) ? A_KICK    : A_KEY;
        logic hit;
        assign hit = bus_wr && (bus_addr == HIT_A);
        wdt_seq_chk #(.ARM(ARM_V), .FIRE(FIRE_V), .GAP_MAX(GAP_MAX)) u_seq (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_hit(hit),
            .wdata (bus_wdata),
            .done  (seq_done[i]),
            .fault (seq_fault[i])
        );
    end

    wdt_regs #(.UNLOCK_WIN(UNLOCK_WIN)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .unlock_done(seq_done[1]),
        .flag_set   (flag_set),
        .bus_rdata  (bus_rdata),
        .en         (en),
        .irq_en     (irq_en),
        .win_en     (win_en),
        .tov        (tov),
        .win        (win),
        .flag       (flag)
    );

    wdt_core #(.WCT(WCT), .RST_LEN(RST_LEN)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .irq_en   (irq_en),
        .win_en   (win_en),
        .tov      (tov),
        .win      (win),
        .kick_done(seq_done[0]),
        .seq_fault(|seq_fault),
        .flag_set (flag_set),
        .wdt_rst  (wdt_rst)
    );

    assign irq = flag;
endmodule

// File: tb/tb_wdt_seq_guard.sv
// Scoreboard bench: scenario tasks push the predicted irq and reset rising
// edges with their cycle numbers. A negedge monitor pops and compares them.
module tb_wdt_seq_guard;
    localparam int WCT = 32;
    localparam int RL  = 4;
    localparam int T   = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, wdt_rst;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct { int sig; int at; string req; } exp_t;
    exp_t q[$];

    wdt_seq_guard #(.WCT(WCT), .RST_LEN(RL)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wdt_rst(wdt_rst)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc = cyc + 1;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic rd_chk(string req, logic [2:0] a, logic [15:0] exp);
        bus_addr = a;
        #1;
        chk(req, {16'd0, bus_rdata}, {16'd0, exp});
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d, output int c);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; c = cyc;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr1(logic [2:0] a, logic [15:0] d);
        int c;
        wr(a, d, c);
    endtask

    task automatic kick(output int k);
        wr1(3'd6, 16'hA602);
        wr(3'd6, 16'hB480, k);
    endtask

    task automatic unlock(output int u);
        wr1(3'd7, 16'hC520);
        wr(3'd7, 16'hD928, u);
    endtask

    task automatic expect_ev(int sig, int at, string req);
        exp_t e;
        e.sig = sig; e.at = at; e.req = req;
        q.push_back(e);
    endtask

    task automatic wait_until(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic clear_flag();
        wr1(3'd1, 16'h8000);
    endtask

    // Monitor: compare each rising edge of irq or wdt_rst with the next prediction.
    logic irq_p = 1'b0, rst_p = 1'b0;
    task automatic take(int sig);
        exp_t e;
        total++;
        if (q.size() == 0) begin
            bad++;
            $display("FAIL R7 unexpected rise sig=%0d actual=%0d expected=none", sig, cyc);
        end else begin
            e = q.pop_front();
            if (e.sig != sig || e.at != cyc) begin
                bad++;
                $display("FAIL %s edge actual sig=%0d cyc=%0d expected sig=%0d cyc=%0d",
                         e.req, sig, cyc, e.sig, e.at);
            end
        end
    endtask
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq && !irq_p)     take(0);
            if (wdt_rst && !rst_p) take(1);
        end
        irq_p = irq;
        rst_p = wdt_rst;
    end

    // Watchdog on the bench itself.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int k, u, f, t, k2;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1", 3'd0, 16'h01D3);
        rd_chk("R1", 3'd1, 16'h0001);
        rd_chk("R1", 3'd2, 16'h004C);
        rd_chk("R1", 3'd3, 16'h4B4C);
        rd_chk("R1", 3'd4, 16'h0000);
        rd_chk("R1", 3'd5, 16'h0010);
        chk("R1", {31'd0, irq}, 0);
        chk("R1", {31'd0, wdt_rst}, 0);

        // R2 locked write is ignored
        wr1(3'd3, 16'h1234);
        rd_chk("R2", 3'd3, 16'h4B4C);

        // R9 bad refresh with interrupt disabled: reset next cycle, no irq
        k = cyc + 1;
        expect_ev(1, k + 1, "R9");
        wr1(3'd6, 16'hA602);
        wr1(3'd6, 16'h1234);
        wait_until(k + RL);
        chk("R12", {31'd0, wdt_rst}, 1);
        chk("R9", {31'd0, irq}, 0);
        wait_until(k + 1 + RL);
        chk("R12", {31'd0, wdt_rst}, 0);

        // R2 window boundary: 257 cycles rejected, 256 accepted
        unlock(u);
        wait_until(u + 257);
        wr1(3'd4, 16'h0005);
        rd_chk("R2", 3'd4, 16'h0000);
        unlock(u);
        wait_until(u + 256);
        wr1(3'd4, 16'h0007);
        rd_chk("R2", 3'd4, 16'h0007);

        // Configure: T=200, interrupt on
        unlock(u);
        wr1(3'd2, 16'h0000);
        wr1(3'd3, T[15:0]);
        wr1(3'd4, 16'h0000);
        wr1(3'd0, 16'h01D7);
        rd_chk("R2", 3'd3, T[15:0]);
        rd_chk("R2", 3'd0, 16'h01D7);
        kick(k);

        // R3 refresh with a 20-cycle gap is accepted
        wr(3'd6, 16'hA602, f);
        wait_until(f + 20);
        wr1(3'd6, 16'hB480);
        repeat (5) @(negedge clk);
        chk("R3", {31'd0, irq}, 0);
        chk("R3", {31'd0, wdt_rst}, 0);

        // R5 refresh second word never comes; R7 delayed reset; R8 flag clear
        f = cyc;
        expect_ev(0, f + 21, "R5");
        expect_ev(1, f + 21 + WCT, "R7");
        wr1(3'd6, 16'hA602);
        wait_until(f + 22);
        rd_chk("R5", 3'd1, 16'h8001);
        wr1(3'd1, 16'h0000);
        rd_chk("R8", 3'd1, 16'h8001);
        wait_until(f + 22 + WCT + RL);
        clear_flag();
        rd_chk("R8", 3'd1, 16'h0001);
        chk("R8", {31'd0, irq}, 0);
        kick(k);

        // R4 unlock with a wrong second word
        t = cyc;
        expect_ev(0, t + 2, "R4");
        expect_ev(1, t + 2 + WCT, "R7");
        wr1(3'd7, 16'hC520);
        wr1(3'd7, 16'h1111);
        wait_until(t + 3 + WCT + RL);
        clear_flag();
        kick(k);

        // R5 unlock second word never comes
        f = cyc;
        expect_ev(0, f + 21, "R5");
        expect_ev(1, f + 21 + WCT, "R7");
        wr1(3'd7, 16'hC520);
        wait_until(f + 22 + WCT + RL);
        clear_flag();
        kick(k);

        // R6 time-out, then R7 reset after the grace period
        kick(k);
        expect_ev(0, k + 2 + T, "R6");
        expect_ev(1, k + 2 + T + WCT, "R7");
        wait_until(k + 3 + T + WCT + RL);
        clear_flag();
        kick(k);

        // R10 time-out inside the grace period forces an early reset
        kick(k);
        wait_until(k + T - 10);
        expect_ev(0, k + T - 8, "R4");
        expect_ev(1, k + 2 + T, "R10");
        wr1(3'd6, 16'hA602);
        wr1(3'd6, 16'h2222);
        wait_until(k + 1 + T + RL);
        chk("R12", {31'd0, wdt_rst}, 1);
        wait_until(k + 2 + T + RL);
        chk("R12", {31'd0, wdt_rst}, 0);
        clear_flag();
        kick(k);

        // R11 windowing: early refresh faults, elapsed == window accepted
        unlock(u);
        wr1(3'd5, 16'd50);
        wr1(3'd0, 16'h01DF);
        repeat (60) @(negedge clk);
        kick(k);
        wait_until(k + 9);
        expect_ev(0, k + 11, "R11");
        expect_ev(1, k + 11 + WCT, "R11");
        wr1(3'd6, 16'hA602);
        wr1(3'd6, 16'hB480);
        wait_until(k + 12 + WCT + RL);
        clear_flag();
        wait_until(k + 60);
        kick(k2);
        wait_until(k2 + 50);
        wr1(3'd6, 16'hA602);
        wr1(3'd6, 16'hB480);
        repeat (4) @(negedge clk);
        chk("R11", {31'd0, irq}, 0);
        chk("R11", {31'd0, wdt_rst}, 0);

        repeat (5) @(negedge clk);
        chk("R7", q.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule